// File: doc/BRIEF.md
# Power-Amplifier Ramp Shaper Sequencer

This block produces the digital envelope control word for a transmitter power amplifier over one burst. A host first loads a 64-word shape table. Each 10-bit word carries two independent 5-bit profiles: the low half shapes the rise and the high half shapes the fall. The host also writes a configuration word. It holds an 8-bit output level, a 4-bit start delay, a rate-select bit and a power-down bit.

When the burst-enable input rises, the sequencer counts off the programmed number of quarter-bit ticks. It then walks the table upward and emits the low-half profile. After the top address it holds the last rising value. When burst enable falls, it waits the same delay, walks the table downward and emits the high-half profile. It then returns to idle. The output word is the current profile value multiplied by the level. Two single-cycle enables pace the block: one marks the quarter-bit period and one marks the table step period.

Top module: `pa_ramp_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `ramp_out` is 0.
- R2: Writes to the shape table are accepted only while the sequencer is idle. A write made during a burst leaves the stored word unchanged, and this shows at the output when that word is later played.
- R3: After the rising edge of `burst_en`, `ramp_out` stays 0 until `cfg_delay` pulses of `tick_qbit` have arrived. Then the rise starts at address 0.
- R4: During the rise, the table is stepped through addresses 0,1,…,62 in ascending order. The shape value is bits [4:0] of the word.
- R5: After address 62 the sequencer holds. While `burst_en` stays high, the output stays at the address-62 rising value, and further step ticks have no effect.
- R6: When `burst_en` goes low in the hold phase, the hold value is kept for `cfg_delay` quarter-bit ticks. The table is then stepped through addresses 63,62,…,1 with shape bits [9:5]. After address 1 the sequencer goes idle and the output is 0.
- R7: With `cfg_slow` = 0, every `tick_step` pulse advances the address. With `cfg_slow` = 1, only every second pulse within a ramp advances it, starting with the second.
- R8: While the power-down bit is set, `ramp_out` is 0 from the cycle after it is registered. Clearing the bit brings back the product.
- R9: While the level register is 0, `ramp_out` is 0.
- R10: Otherwise `ramp_out` is the 13-bit unsigned product of the 5-bit shape value and the 8-bit level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shp_we | input | 1 | Shape table write strobe |
| shp_addr | input | 6 | Shape table write address |
| shp_wdata | input | 10 | Shape word: [9:5] fall profile, [4:0] rise profile |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_level | input | 8 | Output level |
| cfg_delay | input | 4 | Start delay in quarter-bit ticks |
| cfg_slow | input | 1 | 1 = advance on every second step tick |
| cfg_pdown | input | 1 | 1 = force output to zero |
| burst_en | input | 1 | Burst enable; rising edge starts the rise, low in hold starts the fall |
| tick_qbit | input | 1 | Quarter-bit period enable |
| tick_step | input | 1 | Table step period enable |
| ramp_out | output | 13 | Envelope control word |

## Verification
The table address and the sequencer state are registered on the edge that samples a tick or an edge of `burst_en`. The output register follows one edge later, so every output result is due two rising edges after the stimulus. The last quarter-bit tick of a delay needs one further edge to leave the delay state, so the first ramp value is due three edges after that tick. The bench drives each stimulus on a falling edge and returns on the falling edge after it is consumed. It then waits one more falling edge for step results and for configuration results, and three more for a delay end. It compares only at those points. Before the last delay tick it waits several cycles and confirms that the output is still zero or still at the hold value.

// File: rtl/ramp_pkg.sv
// Shared types and constants for the ramp shaper sequencer.
// Assumes a table of 2**ADDR_W words, each with two shape halves.
package ramp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DELAY     = 3'd1,
        ST_RAMP_UP   = 3'd2,
        ST_HOLD      = 3'd3,
        ST_RAMP_DOWN = 3'd4
    } ramp_state_t;
endpackage

// File: rtl/ramp_shape_mem.sv
// Shape table: DEPTH words, each holding a rise half (low) and a fall half (high).
// Assumes the host loads it before use; the contents are not reset.
// Writes land only when wr_allow is high (sequencer idle).
module ramp_shape_mem #(
    parameter int DEPTH  = 64,
    parameter int HALF_W = 5,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_allow,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rd_up,
    output logic [HALF_W-1:0] rd_down
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_word;

    // Gated host write into the table.
    always_ff @(posedge clk) begin
        if (wr_en && wr_allow) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Asynchronous read of the addressed word.
    always_comb begin
        rd_word = mem[rd_addr];
    end

    // Split the word into its two profile halves.
    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            if (h == 0) begin : g_up
                assign rd_up = rd_word[HALF_W-1:0];
            end else begin : g_down
                assign rd_down = rd_word[WORD_W-1:HALF_W];
            end
        end
    endgenerate
endmodule

// File: rtl/ramp_delay_cnt.sv
// Start-delay counter: loaded with the programmed delay and counted down
// on quarter-bit ticks. done is high once the count has reached zero.
module ramp_delay_cnt #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             done
);
    logic [DLY_W-1:0] cnt;

    // Load on request, otherwise count down one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/ramp_step_gen.sv
// Step-rate divider: passes every step tick in fast mode and every second
// tick in slow mode. The phase is cleared outside the ramps, so the first
// slow step falls on the second tick of a ramp.
module ramp_step_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic slow,
    input  logic tick,
    output logic step
);
    logic phase;

    // Track odd/even tick position within the current ramp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else if (clear) begin
            phase <= 1'b0;
        end else if (tick && slow) begin
            phase <= ~phase;
        end
    end

    assign step = tick && (!slow || phase);
endmodule

// File: rtl/ramp_seq_fsm.sv
// Burst sequencer: idle -> delay -> rise -> hold -> delay -> fall -> idle.
// Drives the table address, asks the delay counter to reload, and tells
// the output stage which half and gating apply.
// Assumes burst_rise is a one-cycle pulse on the rising edge of burst enable.
module ramp_seq_fsm
    import ramp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en,
    input  logic              burst_rise,
    input  logic              dly_done,
    input  logic              step,
    output ramp_state_t       st,
    output logic [ADDR_W-1:0] addr,
    output logic              going_down,
    output logic              dly_load
);
    localparam logic [ADDR_W-1:0] UP_END   = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] DOWN_TOP = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] DOWN_END = ADDR_W'(1);

    ramp_state_t       st_n;
    logic [ADDR_W-1:0] addr_n;
    logic              down_n;

    // Next-state, address and direction decode.
    always_comb begin
        st_n   = st;
        addr_n = addr;
        down_n = going_down;
        case (st)
            ST_IDLE: begin
                if (burst_rise) begin
                    st_n   = ST_DELAY;
                    down_n = 1'b0;
                end
            end
            ST_DELAY: begin
                if (dly_done) begin
                    if (going_down) begin
                        st_n   = ST_RAMP_DOWN;
                        addr_n = DOWN_TOP;
                    end else begin
                        st_n   = ST_RAMP_UP;
                        addr_n = '0;
                    end
                end
            end
            ST_RAMP_UP: begin
                if (step) begin
                    if (addr == UP_END) begin
                        st_n = ST_HOLD;
                    end else begin
                        addr_n = addr + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (!burst_en) begin
                    st_n   = ST_DELAY;
                    down_n = 1'b1;
                end
            end
            ST_RAMP_DOWN: begin
                if (step) begin
                    if (addr == DOWN_END) begin
                        st_n   = ST_IDLE;
                        addr_n = '0;
                    end else begin
                        addr_n = addr - 1'b1;
                    end
                end
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    // The delay counter reloads on every entry into the delay state.
    always_comb begin
        dly_load = ((st == ST_IDLE) && burst_rise) || ((st == ST_HOLD) && !burst_en);
    end

    // State, address and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            addr       <= '0;
            going_down <= 1'b0;
        end else begin
            st         <= st_n;
            addr       <= addr_n;
            going_down <= down_n;
        end
    end
endmodule

// File: rtl/ramp_out_stage.sv
// Output register: the shape value times the level, or zero when gated.
// Assumes the width of out equals the sum of the operand widths.
module ramp_out_stage #(
    parameter int SHAPE_W = 5,
    parameter int LEVEL_W = 8,
    localparam int OUT_W = SHAPE_W + LEVEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHAPE_W-1:0] shape,
    input  logic [LEVEL_W-1:0] level,
    input  logic               force_zero,
    output logic [OUT_W-1:0]   out
);
    logic [OUT_W-1:0] prod;

    // Full-width unsigned product.
    always_comb begin
        prod = OUT_W'(shape) * OUT_W'(level);
    end

    // Register the gated product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out <= '0;
        end else if (force_zero) begin
            out <= '0;
        end else begin
            out <= prod;
        end
    end
endmodule

// File: rtl/pa_ramp_seq.sv
// Top of the ramp shaper sequencer: configuration registers, burst edge
// detection, and the wiring of the table, delay counter, step divider,
// sequencer and output stage. Assumes the tick inputs are one-cycle
// enables that are synchronous to clk.
module pa_ramp_seq
    import ramp_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int SHAPE_W = 5,
    parameter int LEVEL_W = 8,
    parameter int DLY_W   = 4,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WORD_W = 2 * SHAPE_W,
    localparam int OUT_W  = SHAPE_W + LEVEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shp_we,
    input  logic [ADDR_W-1:0]  shp_addr,
    input  logic [WORD_W-1:0]  shp_wdata,
    input  logic               cfg_we,
    input  logic [LEVEL_W-1:0] cfg_level,
    input  logic [DLY_W-1:0]   cfg_delay,
    input  logic               cfg_slow,
    input  logic               cfg_pdown,
    input  logic               burst_en,
    input  logic               tick_qbit,
    input  logic               tick_step,
    output logic [OUT_W-1:0]   ramp_out
);
    logic [LEVEL_W-1:0] level_q;
    logic [DLY_W-1:0]   delay_q;
    logic               slow_q;
    logic               pdown_q;
    logic               burst_q;
    logic               burst_rise;
    logic               dly_done;
    logic               dly_load;
    logic               step;
    logic               going_down;
    logic               in_ramp;
    logic               force_zero;
    logic [ADDR_W-1:0]  rd_addr;
    logic [SHAPE_W-1:0] up_val;
    logic [SHAPE_W-1:0] down_val;
    logic [SHAPE_W-1:0] shape;
    ramp_state_t        st;

    // Configuration registers, written as one word by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            delay_q <= '0;
            slow_q  <= 1'b0;
            pdown_q <= 1'b0;
        end else if (cfg_we) begin
            level_q <= cfg_level;
            delay_q <= cfg_delay;
            slow_q  <= cfg_slow;
            pdown_q <= cfg_pdown;
        end
    end

    // Previous burst enable, for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
        end else begin
            burst_q <= burst_en;
        end
    end

    assign burst_rise = burst_en && !burst_q;

    ramp_shape_mem #(.DEPTH(DEPTH), .HALF_W(SHAPE_W)) u_mem (
        .clk      (clk),
        .wr_en    (shp_we),
        .wr_allow (st == ST_IDLE),
        .wr_addr  (shp_addr),
        .wr_data  (shp_wdata),
        .rd_addr  (rd_addr),
        .rd_up    (up_val),
        .rd_down  (down_val)
    );

    ramp_delay_cnt #(.DLY_W(DLY_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (delay_q),
        .tick     (tick_qbit),
        .done     (dly_done)
    );

    assign in_ramp = (st == ST_RAMP_UP) || (st == ST_RAMP_DOWN);

    ramp_step_gen u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!in_ramp),
        .slow  (slow_q),
        .tick  (tick_step),
        .step  (step)
    );

    ramp_seq_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_en   (burst_en),
        .burst_rise (burst_rise),
        .dly_done   (dly_done),
        .step       (step),
        .st         (st),
        .addr       (rd_addr),
        .going_down (going_down),
        .dly_load   (dly_load)
    );

    // Select the profile half and the zero gating for the output stage.
    always_comb begin
        shape      = (st == ST_RAMP_DOWN) ? down_val : up_val;
        force_zero = pdown_q || (level_q == '0) || (st == ST_IDLE)
                     || ((st == ST_DELAY) && !going_down);
    end

    ramp_out_stage #(.SHAPE_W(SHAPE_W), .LEVEL_W(LEVEL_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .shape      (shape),
        .level      (level_q),
        .force_zero (force_zero),
        .out        (ramp_out)
    );
endmodule

// File: rtl/pa_ramp_seq_chk.sv
// Assertion checker for pa_ramp_seq, attached with bind below.
// Observes the sequencer state, the table address, the step enable,
// the configuration registers and the output word.
module pa_ramp_seq_chk
    import ramp_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LEVEL_W = 8,
    parameter int OUT_W   = 13,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic               clk,
    input logic               rst_n,
    input ramp_state_t        st,
    input logic [ADDR_W-1:0]  addr,
    input logic               step,
    input logic               pdown_q,
    input logic [LEVEL_W-1:0] level_q,
    input logic [OUT_W-1:0]   ramp_out
);
    localparam logic [ADDR_W-1:0] UP_END   = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] DOWN_END = ADDR_W'(1);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (ramp_out == '0)); // R1

    AST_UP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RAMP_UP) |-> (addr <= UP_END)); // R4

    AST_UP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RAMP_UP) && step && (addr != UP_END))
            |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R4

    AST_DOWN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RAMP_DOWN) |-> (addr >= DOWN_END)); // R6

    AST_DOWN_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RAMP_DOWN) && step && (addr != DOWN_END))
            |=> (addr == ADDR_W'($past(addr) - 1'b1))); // R6

    AST_NO_STEP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RAMP_UP) && !step) |=> $stable(addr)); // R7

    AST_PDOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pdown_q |=> (ramp_out == '0)); // R8

    AST_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == '0) |=> (ramp_out == '0)); // R9
endmodule

bind pa_ramp_seq pa_ramp_seq_chk #(
    .DEPTH   (DEPTH),
    .LEVEL_W (LEVEL_W),
    .OUT_W   (OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .addr     (rd_addr),
    .step     (step),
    .pdown_q  (pdown_q),
    .level_q  (level_q),
    .ramp_out (ramp_out)
);

// File: tb/pa_ramp_seq_tb.sv
`timescale 1ns/1ps
module pa_ramp_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shp_we = 1'b0;
    logic [5:0]  shp_addr = '0;
    logic [9:0]  shp_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_level = '0;
    logic [3:0]  cfg_delay = '0;
    logic        cfg_slow = 1'b0;
    logic        cfg_pdown = 1'b0;
    logic        burst_en = 1'b0;
    logic        tick_qbit = 1'b0;
    logic        tick_step = 1'b0;
    logic [12:0] ramp_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pa_ramp_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .shp_we(shp_we), .shp_addr(shp_addr), .shp_wdata(shp_wdata),
        .cfg_we(cfg_we), .cfg_level(cfg_level), .cfg_delay(cfg_delay),
        .cfg_slow(cfg_slow), .cfg_pdown(cfg_pdown),
        .burst_en(burst_en), .tick_qbit(tick_qbit), .tick_step(tick_step),
        .ramp_out(ramp_out)
    );

    function automatic int f_up(int a, int s);
        return (a * 3 + s) % 32;
    endfunction

    function automatic int f_dn(int a, int s);
        return (a * 11 + s + 5) % 32;
    endfunction

    task automatic check(int exp, string req);
        total++;
        if (int'(ramp_out) != exp) begin
            bad++;
            $display("FAIL %s: ramp_out=%0d expected=%0d at %0t", req, ramp_out, exp, $time);
        end
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_word(int a, logic [9:0] w);
        @(negedge clk);
        shp_we = 1'b1; shp_addr = 6'(a); shp_wdata = w;
        @(negedge clk);
        shp_we = 1'b0;
    endtask

    task automatic load_table(int s);
        for (int a = 0; a < 64; a++) write_word(a, {5'(f_dn(a, s)), 5'(f_up(a, s))});
    endtask

    task automatic set_cfg(int lvl, int dly, bit slow, bit pd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_level = 8'(lvl); cfg_delay = 4'(dly);
        cfg_slow = slow; cfg_pdown = pd;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic qtick();
        @(negedge clk); tick_qbit = 1'b1;
        @(negedge clk); tick_qbit = 1'b0;
    endtask

    task automatic spulse();
        @(negedge clk); tick_step = 1'b1;
        @(negedge clk); tick_step = 1'b0;
    endtask

    // One address advance; in slow mode the first pulse must not move it.
    task automatic advance(bit slow, int prev_exp, int exp, string req);
        if (slow) begin
            spulse(); wait_neg(1);
            check(prev_exp, "R7 slow first pulse");
        end
        spulse(); wait_neg(1);
        check(exp, req);
    endtask

    // A full burst; mid_pd toggles power-down during the hold phase.
    task automatic run_burst(int s, int lvl, int dly, bit slow, bit pd, bit mid_pd);
        int g;
        logic [9:0] orig63;
        g = (pd || lvl == 0) ? 0 : lvl;
        load_table(s);
        set_cfg(lvl, dly, slow, pd);
        wait_neg(2);
        check(0, "R1 idle before burst");
        @(negedge clk); burst_en = 1'b1;
        @(negedge clk);
        if (dly > 0) begin
            for (int i = 0; i < dly - 1; i++) qtick();
            wait_neg(4);
            check(0, "R3 delay not yet elapsed");
            qtick();
        end
        wait_neg(3);
        check(f_up(0, s) * g, "R3 rise starts at address 0");
        for (int a = 1; a <= 62; a++)
            advance(slow, f_up(a - 1, s) * g, f_up(a, s) * g, "R4 rise value");
        advance(slow, f_up(62, s) * g, f_up(62, s) * g, "R5 hold ignores steps");
        advance(slow, f_up(62, s) * g, f_up(62, s) * g, "R5 hold ignores steps");
        orig63 = {5'(f_dn(63, s)), 5'(f_up(63, s))};
        write_word(63, ~orig63);
        wait_neg(1);
        check(f_up(62, s) * g, "R2 hold after blocked write");
        if (mid_pd) begin
            set_cfg(lvl, dly, slow, 1'b1);
            wait_neg(1);
            check(0, "R8 power-down forces zero");
            set_cfg(lvl, dly, slow, pd);
            wait_neg(1);
            check(f_up(62, s) * g, "R8 power-up restores");
        end
        @(negedge clk); burst_en = 1'b0;
        @(negedge clk);
        if (dly > 0) begin
            for (int i = 0; i < dly - 1; i++) qtick();
            wait_neg(4);
            check(f_up(62, s) * g, "R6 hold during fall delay");
            qtick();
        end
        wait_neg(3);
        check(f_dn(63, s) * g, "R2 R6 fall starts at address 63, write blocked");
        for (int a = 62; a >= 1; a--)
            advance(slow, f_dn(a + 1, s) * g, f_dn(a, s) * g, "R6 fall value");
        advance(slow, f_dn(1, s) * g, 0, "R6 idle after address 1");
        wait_neg(3);
        check(0, "R1 idle after burst");
    endtask

    initial begin
        wait_neg(4);
        check(0, "R1 reset value");
        @(negedge clk); rst_n = 1'b1;
        wait_neg(2);
        check(0, "R1 idle after reset");
        run_burst(1, 1, 0, 1'b0, 1'b0, 1'b0);     // R10 smallest level
        run_burst(7, 255, 15, 1'b1, 1'b0, 1'b0);  // R10 largest level, R3 max delay
        run_burst(2, 37, 3, 1'b0, 1'b0, 1'b1);    // R8 mid-burst power-down
        run_burst(9, 0, 1, 1'b1, 1'b0, 1'b0);     // R9 level zero
        run_burst(4, 200, 2, 1'b0, 1'b1, 1'b0);   // R8 power-down throughout
        run_burst(12, 130, 5, 1'b0, 1'b0, 1'b0);  // R10 mid level, R3 mid delay
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule